// File: doc/BRIEF.md
# CAN Interrupt Identifier Arbiter

This block turns the interrupt sources of a CAN controller into a single 16-bit identifier and one level interrupt line for the CPU. It has two kinds of source. The first is one status source, which the protocol core raises each time it writes its status register. The second is a bank of message objects, and each object supplies its own pending bit. The identifier always names the most important pending source. The order in which the sources became pending plays no part in the choice.

The status source has its own pending latch inside the block. A CPU read of the status register clears it, and a CPU write to that register has no effect on it. Message-object pending bits are held outside the block. When software clears one of them, the identifier moves on to the next pending object. The identifier keeps tracking the sources whether or not the global enable is set. The global enable only gates the interrupt line.

Top module: `canint_id_arb`

## Requirements
- R1: When neither the status source nor any message object is pending, `irq_id` is 0.
- R2: A pending status interrupt has priority over every message object and is reported as `irq_id` = 0x8000.
- R3: Bit i of `obj_pend` belongs to message object i+1 (objects 1 to 32). The code reported for an object equals its number. The lowest-numbered pending object is reported, whatever the order of arrival.
- R4: A cycle with `core_stat_wr` high makes the status interrupt pending, even if the status value is unchanged. The matching enable must be set: `err_irq_en` when `core_stat_err` is 1, and `stat_irq_en` when `core_stat_err` is 0.
- R5: A cycle with `cpu_stat_rd` high clears the pending status interrupt. `cpu_stat_wr` never sets or clears it.
- R6: When a status read and an enabled status update fall in the same cycle, the status interrupt stays pending.
- R7: `irq_line` is 1 exactly when `irq_id` is nonzero and `glb_irq_en` was 1 in the cycle that produced that `irq_id`.
- R8: `irq_id` follows the pending sources while `glb_irq_en` is 0.
- R9: `irq_id` and `irq_line` are registered. They reflect the inputs sampled at the preceding clock edge, and a change to the inputs is not visible before that edge.
- R10: While and right after `rst` is high, `irq_id` is 0, `irq_line` is 0 and no status interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_pend | input | 32 | Message-object pending bits, bit i = object i+1 |
| core_stat_wr | input | 1 | Protocol core wrote the status register this cycle |
| core_stat_err | input | 1 | That write is an error update (1) or a status update (0) |
| err_irq_en | input | 1 | Enable for error-update interrupts |
| stat_irq_en | input | 1 | Enable for status-update interrupts |
| glb_irq_en | input | 1 | Global enable for the interrupt line |
| cpu_stat_rd | input | 1 | CPU read strobe of the status register |
| cpu_stat_wr | input | 1 | CPU write strobe of the status register |
| irq_id | output | 16 | Identifier of the highest-priority pending source |
| irq_line | output | 1 | Level interrupt request to the CPU |

## Verification
The bench uses the default build: 32 message objects, a 16-bit identifier and a status code of 0x8000. With these values both ends of the object range are reachable. Object 1 has the top object priority and object 32 sets the highest bit of the object code, so the bench can check that the object code and the status code never overlap. A randomized phase drives the status strobes and enables against a behavioural model. This exercises same-cycle collisions between status reads and updates, as well as enable changes in the middle of a burst.

// File: rtl/canint_pkg.sv
package canint_pkg;
  localparam int unsigned DEF_NUM_OBJ   = 32;
  localparam int unsigned DEF_ID_W      = 16;
  localparam logic [15:0] DEF_STAT_CODE = 16'h8000;

  typedef struct packed {
    logic upd;
    logic is_err;
  } stat_evt_t;

  function automatic logic evt_enabled(stat_evt_t e, logic err_en, logic stat_en);
    return e.upd && (e.is_err ? err_en : stat_en);
  endfunction
endpackage

// File: rtl/canint_stat_latch.sv
module canint_stat_latch
  import canint_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  stat_evt_t evt,
  input  logic      err_en,
  input  logic      stat_en,
  input  logic      cpu_rd,
  output logic      pend_nxt,
  output logic      pend_q
);
  logic set_now;

  always_comb begin
    set_now = evt_enabled(evt, err_en, stat_en);
    if (set_now)      pend_nxt = 1'b1;
    else if (cpu_rd)  pend_nxt = 1'b0;
    else              pend_nxt = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_nxt;
  end
endmodule

// File: rtl/canint_prio_enc.sv
module canint_prio_enc #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned CODE_W  = $clog2(NUM_OBJ + 1)
) (
  input  logic [NUM_OBJ-1:0] pend,
  output logic [CODE_W-1:0]  code
);
  logic [NUM_OBJ-1:0] win;

  genvar g;
  generate
    for (g = 0; g < NUM_OBJ; g++) begin : g_win
      if (g == 0) begin : g_first
        assign win[g] = pend[g];
      end else begin : g_rest
        assign win[g] = pend[g] & ~(|pend[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_OBJ; i++) begin
      if (win[i]) code = code | CODE_W'(i + 1);
    end
  end
endmodule

// File: rtl/canint_id_reg.sv
module canint_id_reg #(
  parameter int unsigned ID_W      = 16,
  parameter int unsigned CODE_W    = 6,
  parameter logic [ID_W-1:0] STAT_CODE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_nxt,
  input  logic [CODE_W-1:0] obj_code,
  input  logic              glb_en,
  output logic [ID_W-1:0]   irq_id,
  output logic              irq_line
);
  localparam int unsigned PAD_W = ID_W - CODE_W;

  logic [ID_W-1:0] id_nxt;
  logic            line_nxt;

  always_comb begin
    id_nxt   = stat_nxt ? STAT_CODE : {{PAD_W{1'b0}}, obj_code};
    line_nxt = glb_en && (id_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_id   <= '0;
      irq_line <= 1'b0;
    end else begin
      irq_id   <= id_nxt;
      irq_line <= line_nxt;
    end
  end
endmodule

// File: rtl/canint_id_arb.sv
module canint_id_arb
  import canint_pkg::*;
#(
  parameter int unsigned NUM_OBJ   = DEF_NUM_OBJ,
  parameter int unsigned ID_W      = DEF_ID_W,
  parameter logic [ID_W-1:0] STAT_CODE = DEF_STAT_CODE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] obj_pend,
  input  logic               core_stat_wr,
  input  logic               core_stat_err,
  input  logic               err_irq_en,
  input  logic               stat_irq_en,
  input  logic               glb_irq_en,
  input  logic               cpu_stat_rd,
  input  logic               cpu_stat_wr,
  output logic [ID_W-1:0]    irq_id,
  output logic               irq_line
);
  localparam int unsigned CODE_W = $clog2(NUM_OBJ + 1);

  stat_evt_t         evt;
  logic              stat_pend_nxt;
  logic              stat_pend_q;
  logic [CODE_W-1:0] obj_code;

  assign evt = '{upd: core_stat_wr, is_err: core_stat_err};

  canint_stat_latch u_stat (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .err_en   (err_irq_en),
    .stat_en  (stat_irq_en),
    .cpu_rd   (cpu_stat_rd),
    .pend_nxt (stat_pend_nxt),
    .pend_q   (stat_pend_q)
  );

  canint_prio_enc #(
    .NUM_OBJ (NUM_OBJ),
    .CODE_W  (CODE_W)
  ) u_enc (
    .pend (obj_pend),
    .code (obj_code)
  );

  canint_id_reg #(
    .ID_W      (ID_W),
    .CODE_W    (CODE_W),
    .STAT_CODE (STAT_CODE)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .stat_nxt (stat_pend_nxt),
    .obj_code (obj_code),
    .glb_en   (glb_irq_en),
    .irq_id   (irq_id),
    .irq_line (irq_line)
  );
endmodule

// File: rtl/canint_id_arb_chk.sv
module canint_id_arb_chk #(
  parameter int unsigned NUM_OBJ   = 32,
  parameter int unsigned ID_W      = 16,
  parameter logic [ID_W-1:0] STAT_CODE = 16'h8000
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OBJ-1:0] obj_pend,
  input logic               core_stat_wr,
  input logic               core_stat_err,
  input logic               err_irq_en,
  input logic               stat_irq_en,
  input logic               glb_irq_en,
  input logic               cpu_stat_rd,
  input logic               cpu_stat_wr,
  input logic               stat_pend_q,
  input logic [ID_W-1:0]    irq_id,
  input logic               irq_line
);
  logic pv;
  logic upd_en;

  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  assign upd_en = core_stat_wr && (core_stat_err ? err_irq_en : stat_irq_en);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (pv && !stat_pend_q && ($past(obj_pend) == '0)) |-> (irq_id == '0));

  assert_stat_code_R2: assert property (@(posedge clk) disable iff (rst)
    stat_pend_q |-> (irq_id == STAT_CODE));

  assert_upd_sets_R4: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> stat_pend_q);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_stat_rd && !core_stat_wr) |=> !stat_pend_q);

  assert_wr_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(cpu_stat_wr && !cpu_stat_rd && !core_stat_wr)) |-> (stat_pend_q == $past(stat_pend_q)));

  assert_upd_beats_rd_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && cpu_stat_rd) |=> stat_pend_q);

  assert_line_needs_id_R7: assert property (@(posedge clk) disable iff (rst)
    irq_line |-> (irq_id != '0));

  assert_line_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(glb_irq_en) && (irq_id != '0)) |-> irq_line);
endmodule

bind canint_id_arb canint_id_arb_chk #(
  .NUM_OBJ   (NUM_OBJ),
  .ID_W      (ID_W),
  .STAT_CODE (STAT_CODE)
) u_chk (.*);

// File: tb/tb_canint_id_arb.sv
`timescale 1ns/1ps
module tb_canint_id_arb;
  localparam int NOBJ = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NOBJ-1:0] obj_pend = '0;
  logic            core_stat_wr = 1'b0, core_stat_err = 1'b0;
  logic            err_irq_en = 1'b0, stat_irq_en = 1'b0, glb_irq_en = 1'b0;
  logic            cpu_stat_rd = 1'b0, cpu_stat_wr = 1'b0;
  logic [15:0]     irq_id;
  logic            irq_line;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  canint_id_arb dut (
    .clk(clk), .rst(rst), .obj_pend(obj_pend),
    .core_stat_wr(core_stat_wr), .core_stat_err(core_stat_err),
    .err_irq_en(err_irq_en), .stat_irq_en(stat_irq_en), .glb_irq_en(glb_irq_en),
    .cpu_stat_rd(cpu_stat_rd), .cpu_stat_wr(cpu_stat_wr),
    .irq_id(irq_id), .irq_line(irq_line)
  );

  // behavioural reference
  bit      m_stat;
  int      m_id;
  bit      m_line;
  always @(posedge clk) begin
    if (rst) begin
      m_stat = 0; m_id = 0; m_line = 0;
    end else begin
      if (core_stat_wr && (core_stat_err ? err_irq_en : stat_irq_en)) m_stat = 1;
      else if (cpu_stat_rd) m_stat = 0;
      m_id = 0;
      if (m_stat) m_id = 'h8000;
      else for (int n = NOBJ; n >= 1; n--) if (obj_pend[n-1]) m_id = n;
      m_line = glb_irq_en && (m_id != 0);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    chk(irq_id, m_id, (m_id == 0) ? "R1 model" : (m_id == 'h8000) ? "R2 model" : "R3 model");
    chk(irq_line, m_line, "R7 model");
  endtask

  task automatic pulse_core(input bit err);
    core_stat_wr = 1; core_stat_err = err;
    tick();
    core_stat_wr = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(irq_id, 0, "R10 id in reset");
    chk(irq_line, 0, "R10 line in reset");
    rst = 0;
    tick();
    chk(irq_id, 0, "R10 id after reset");

    glb_irq_en = 1;
    obj_pend[19] = 1; obj_pend[4] = 1;
    #1 chk(irq_id, 0, "R9 no change before edge");
    tick();
    chk(irq_id, 5, "R3 lowest of 5,20");
    chk(irq_line, 1, "R7 line on");
    obj_pend[0] = 1; tick();
    chk(irq_id, 1, "R3 object 1 wins");
    obj_pend[0] = 0; tick();
    chk(irq_id, 5, "R3 next after clear");
    obj_pend[4] = 0; tick();
    chk(irq_id, 20, "R3 next after clear");

    stat_irq_en = 1; pulse_core(0);
    chk(irq_id, 'h8000, "R4 status update sets");
    tick();
    chk(irq_id, 'h8000, "R2 status held");
    cpu_stat_wr = 1; tick(); cpu_stat_wr = 0; tick();
    chk(irq_id, 'h8000, "R5 write ignored");
    cpu_stat_rd = 1; tick(); cpu_stat_rd = 0;
    chk(irq_id, 20, "R5 read clears");
    cpu_stat_wr = 1; tick(); cpu_stat_wr = 0;
    chk(irq_id, 20, "R5 write does not set");

    stat_irq_en = 0; pulse_core(0);
    chk(irq_id, 20, "R4 status disabled");
    pulse_core(1);
    chk(irq_id, 20, "R4 error disabled");
    err_irq_en = 1; pulse_core(1);
    chk(irq_id, 'h8000, "R4 error enabled");

    cpu_stat_rd = 1; core_stat_wr = 1; core_stat_err = 1;
    tick();
    core_stat_wr = 0;
    chk(irq_id, 'h8000, "R6 update beats read");
    tick(); cpu_stat_rd = 0;
    chk(irq_id, 20, "R6 later read clears");

    glb_irq_en = 0; tick();
    chk(irq_line, 0, "R7 line off when disabled");
    obj_pend = '0; obj_pend[31] = 1; tick();
    chk(irq_id, 32, "R8 id updates while disabled");
    chk(irq_line, 0, "R8 line stays off");
    glb_irq_en = 1; tick();
    chk(irq_line, 1, "R7 line back on");
    obj_pend = '0; tick();
    chk(irq_id, 0, "R1 nothing pending");
    chk(irq_line, 0, "R7 line drops");

    for (int c = 0; c < 400; c++) begin
      obj_pend[$urandom_range(NOBJ - 1)] = $urandom_range(1);
      if ($urandom_range(7) == 0) obj_pend = '0;
      core_stat_wr  = ($urandom_range(5) == 0);
      core_stat_err = $urandom_range(1);
      err_irq_en    = ($urandom_range(3) != 0);
      stat_irq_en   = ($urandom_range(3) != 0);
      glb_irq_en    = ($urandom_range(4) != 0);
      cpu_stat_rd   = ($urandom_range(3) == 0);
      cpu_stat_wr   = ($urandom_range(3) == 0);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule